// File: doc/BRIEF.md
# Channel-Update Serial Frame Transmitter

This block is the host-side master for a three-wire serial link (clock, data, active-low select) that updates one channel of an addressed multi-channel settings device. A client presents a 3-bit channel number and an 8-bit setting, then pulses `start_i` while `busy_o` is low. The block captures both values and pulls select low. It then shifts the channel number and the setting out, most significant bit first, with the data changed only while the serial clock is low. Finally it lets select rise while the clock is high, and that rising edge makes the receiver load the word.

A mode input picks the frame length. In compact mode exactly 11 bits are sent. In byte-aligned mode the address is led by five zero bits, which gives 16 bits that suit hosts that shift whole bytes. The receiver keeps only the last 11 bits it sees. The serial clock half-period and the select-high recovery time are parameters counted in system clock cycles. Two active-low static controls, preset and power-down, pass straight through to the device.

Top module: `chanset_tx`

## Requirements
- R1: After synchronous reset, `sel_n_o` is 1, `sclk_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: `start_i` is accepted only while `busy_o` is 0. A start pulse during a transfer does not lengthen the transfer, does not start a second frame and does not change the frame being sent.
- R3: The channel number, setting and mode are captured in the cycle `start_i` is accepted. Changing `addr_i`, `value_i` or `wide_i` later in the transfer does not change the frame.
- R4: With `wide_i`=0, exactly 11 rising clock edges occur while select is low. At those edges the receiver sees `addr_i[2]`, `addr_i[1]`, `addr_i[0]`, then `value_i[7]` down to `value_i[0]`.
- R5: With `wide_i`=1, exactly 16 rising clock edges occur while select is low. The first five bits are 0, followed by the 3 address bits and the 8 value bits, each field MSB first.
- R6: `sclk_o` idles high, and it is high in the cycle before and the cycle after every change of `sel_n_o`.
- R7: While select is low, `sdo_o` never changes during a run of consecutive cycles in which `sclk_o` is high.
- R8: Every clock level inside a frame, including the select-low setup before the first rising edge, lasts at least `HALF_CYC` system cycles (minimum 1). Select stays high at least `RECOVER_CYC` cycles between frames.
- R9: `busy_o` rises in the cycle after acceptance and stays high for (2·N+2)·`HALF_CYC`+`RECOVER_CYC` cycles, where N is 11 or 16. `done_o` is high for exactly the one cycle in which `busy_o` has just fallen.
- R10: `preset_n_o` follows `preset_n_i` and `pwrdn_n_o` follows `pwrdn_n_i` at all times, whether or not a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a frame; taken when busy_o is low |
| addr_i | input | 3 | Channel number to update |
| value_i | input | 8 | Setting for that channel |
| wide_i | input | 1 | 1 = 16-bit byte-aligned frame, 0 = 11-bit frame |
| preset_n_i | input | 1 | Static preset request, active low |
| pwrdn_n_i | input | 1 | Static power-down request, active low |
| busy_o | output | 1 | Transfer in progress, including recovery time |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data, MSB first |
| sel_n_o | output | 1 | Active-low select; its rise loads the word |
| preset_n_o | output | 1 | Pass-through of preset_n_i |
| pwrdn_n_o | output | 1 | Pass-through of pwrdn_n_i |

## Verification
`busy_o` is high from the first falling system-clock edge after the accepting rising edge. The bench counts the falling edges at which it stays high and compares that count with (2·N+2)·HALF+RECOVER. It then expects `done_o` at the first falling edge where `busy_o` reads low and no longer one cycle after. The serial outputs are registered, so a receiver model samples them at every falling system edge. It treats a low-to-high change of `sclk_o` as the sampling point and a rise of `sel_n_o` as the load. This makes the frame contents, bit counts, level widths and select gaps independent of the exact cycle offsets. The pass-through outputs are combinational and are checked one time step after their inputs change.

// File: rtl/chanset_pkg.sv
package chanset_pkg;

    localparam int ADDR_W  = 3;
    localparam int VAL_W   = 8;
    localparam int FRAME_W = 16;
    localparam int CNT_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } tx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [VAL_W-1:0]  value;
        logic              wide;
    } tx_req_t;

    // Left-aligned frame: bit FRAME_W-1 goes out first.
    function automatic logic [FRAME_W-1:0] pack_frame(input tx_req_t req);
        if (req.wide)
            return {5'b0, req.addr, req.value};
        else
            return {req.addr, req.value, 5'b0};
    endfunction

    // Index of the final bit (bit count minus one).
    function automatic logic [CNT_W-1:0] last_index(input logic wide);
        return wide ? CNT_W'(FRAME_W - 1) : CNT_W'(ADDR_W + VAL_W - 1);
    endfunction

endpackage

// File: rtl/chanset_timer.sv
module chanset_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/chanset_shifter.sv
module chanset_shifter
    import chanset_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  tx_req_t req_i,
    input  logic    shift_i,
    output logic    sdo_o,
    output logic    last_o
);
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sh_q   <= pack_frame(req_i);
            left_q <= last_index(req_i.wide);
        end else if (shift_i) begin
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign sdo_o  = sh_q[FRAME_W-1];
    assign last_o = (left_q == '0);

    // R4/R5: the sequencer never shifts beyond the frame length.
    a_r4_no_overshift: assert property (@(posedge clk) disable iff (rst)
        shift_i |-> (left_q != '0));
endmodule

// File: rtl/chanset_seq.sv
module chanset_seq
    import chanset_pkg::*;
#(
    parameter int HALF   = 1,
    parameter int RECOV  = 1,
    parameter int TW     = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          expire_i,
    input  logic          last_i,
    output logic          tload_o,
    output logic [TW-1:0] tval_o,
    output logic          capture_o,
    output logic          shift_o,
    output logic          sclk_o,
    output logic          sel_n_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [TW-1:0] HALF_LD  = TW'(HALF - 1);
    localparam logic [TW-1:0] RECOV_LD = TW'(RECOV - 1);

    tx_state_e state_q, state_d;
    logic      done_d;
    logic      sclk_q, sel_n_q, busy_q, done_q;

    always_comb begin
        state_d   = state_q;
        tload_o   = 1'b0;
        tval_o    = HALF_LD;
        capture_o = 1'b0;
        shift_o   = 1'b0;
        done_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d   = ST_SETUP;
                tload_o   = 1'b1;
                capture_o = 1'b1;
            end
            ST_SETUP: if (expire_i) begin
                state_d = ST_LOW;
                tload_o = 1'b1;
            end
            ST_LOW: if (expire_i) begin
                state_d = ST_HIGH;
                tload_o = 1'b1;
            end
            ST_HIGH: if (expire_i) begin
                tload_o = 1'b1;
                if (last_i) begin
                    state_d = ST_TAIL;
                end else begin
                    state_d = ST_LOW;
                    shift_o = 1'b1;
                end
            end
            ST_TAIL: if (expire_i) begin
                state_d = ST_GAP;
                tload_o = 1'b1;
                tval_o  = RECOV_LD;
            end
            ST_GAP: if (expire_i) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b1;
            sel_n_q <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sclk_q  <= (state_d != ST_LOW);
            sel_n_q <= (state_d == ST_IDLE) || (state_d == ST_GAP);
            busy_q  <= (state_d != ST_IDLE);
            done_q  <= done_d;
        end
    end

    assign sclk_o  = sclk_q;
    assign sel_n_o = sel_n_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;

    // R2: a capture happens only from the idle, not-busy condition.
    a_r2_capture_idle: assert property (@(posedge clk) disable iff (rst)
        capture_o |-> !busy_q);
endmodule

// File: rtl/chanset_tx.sv
module chanset_tx
    import chanset_pkg::*;
#(
    parameter int HALF_CYC    = 4,
    parameter int RECOVER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [VAL_W-1:0]  value_i,
    input  logic              wide_i,
    input  logic              preset_n_i,
    input  logic              pwrdn_n_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              sel_n_o,
    output logic              preset_n_o,
    output logic              pwrdn_n_o
);
    localparam int HALF_EFF  = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int RECOV_EFF = (RECOVER_CYC < 1) ? 1 : RECOVER_CYC;
    localparam int SPAN      = (HALF_EFF > RECOV_EFF) ? HALF_EFF : RECOV_EFF;
    localparam int TW        = (SPAN < 2) ? 1 : $clog2(SPAN);

    tx_req_t       req;
    logic          tload, capture, shift, expire, last;
    logic [TW-1:0] tval;

    assign req = '{addr: addr_i, value: value_i, wide: wide_i};

    chanset_seq #(
        .HALF  (HALF_EFF),
        .RECOV (RECOV_EFF),
        .TW    (TW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .expire_i  (expire),
        .last_i    (last),
        .tload_o   (tload),
        .tval_o    (tval),
        .capture_o (capture),
        .shift_o   (shift),
        .sclk_o    (sclk_o),
        .sel_n_o   (sel_n_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    chanset_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tload),
        .load_val_i (tval),
        .expire_o   (expire)
    );

    chanset_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (capture),
        .req_i   (req),
        .shift_i (shift),
        .sdo_o   (sdo_o),
        .last_o  (last)
    );

    assign preset_n_o = preset_n_i;
    assign pwrdn_n_o  = pwrdn_n_i;

    // R6: select only changes while the serial clock is held high.
    a_r6_sel_edge_clk_high: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel_n_o) || $fell(sel_n_o)) |-> (sclk_o && $past(sclk_o)));

    // R7: data is steady across a high clock level inside a frame.
    a_r7_data_steady: assert property (@(posedge clk) disable iff (rst)
        (!sel_n_o && !$past(sel_n_o) && sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R9: done is a single-cycle pulse as busy falls.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: no new frame opens while a transfer is already running.
    a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n_o) |-> !$past(busy_o));
endmodule

// File: tb/chanset_tx_bench.sv
module chanset_tx_bench;
    localparam int HALF = 2;
    localparam int RECOV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] value_i = '0;
    logic       wide_i = 1'b0;
    logic       preset_n_i = 1'b1;
    logic       pwrdn_n_i = 1'b1;
    logic busy_o, done_o, sclk_o, sdo_o, sel_n_o, preset_n_o, pwrdn_n_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    chanset_tx #(.HALF_CYC(HALF), .RECOVER_CYC(RECOV)) u_chanset_tx (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
        .value_i(value_i), .wide_i(wide_i), .preset_n_i(preset_n_i),
        .pwrdn_n_i(pwrdn_n_i), .busy_o(busy_o), .done_o(done_o),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .sel_n_o(sel_n_o),
        .preset_n_o(preset_n_o), .pwrdn_n_o(pwrdn_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input bit w);
        int n = w ? 16 : 11;
        return (2 * n + 2) * HALF + RECOV;
    endfunction

    function automatic int exp_word(input logic [2:0] a, input logic [7:0] v);
        return int'({5'b0, a, v});
    endfunction

    // Receiver model, sampled away from the active edge.
    logic        p_sclk = 1'b1, p_sel = 1'b1, p_sdo = 1'b0;
    logic [15:0] rx_word = '0;
    int rx_cnt = 0, last_cnt = 0, frames = 0;
    logic [15:0] last_word = '0;
    int run = 0, min_level = 1000, gap = 0, min_gap = 1000;
    bit r7_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_sel && !sel_n_o) begin
                check(p_sclk && sclk_o, "R6 clock high at select fall", sclk_o, 1);
                rx_cnt = 0; rx_word = '0; run = 1; r7_bad = 1'b0;
                if (frames > 0 && gap < min_gap) min_gap = gap;
            end else if (!sel_n_o) begin
                if (sclk_o && !p_sclk) begin
                    rx_word = {rx_word[14:0], sdo_o};
                    rx_cnt++;
                end
                if (sclk_o && p_sclk && (sdo_o != p_sdo)) r7_bad = 1'b1;
                if (sclk_o != p_sclk) begin
                    if (run < min_level) min_level = run;
                    run = 1;
                end else run++;
            end
            if (!p_sel && sel_n_o) begin
                check(p_sclk && sclk_o, "R6 clock high at select rise", sclk_o, 1);
                check(!r7_bad, "R7 data steady while clock high", r7_bad, 0);
                last_word = rx_word; last_cnt = rx_cnt; frames++; gap = 1;
            end else if (sel_n_o) gap++;
            p_sclk = sclk_o; p_sel = sel_n_o; p_sdo = sdo_o;
        end
    end

    task automatic run_frame(input logic [2:0] a, input logic [7:0] v, input bit w,
                             input bit disturb, input bit restart);
        int n = 0;
        int f0;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        f0 = frames;
        start_i = 1'b1; addr_i = a; value_i = v; wide_i = w;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o && n < 5000) begin
            n++;
            if (disturb && n == 3) begin
                addr_i = 3'($urandom); value_i = 8'($urandom); wide_i = ~w;
            end
            if (restart && n == 5) begin
                start_i = 1'b1; addr_i = ~a; value_i = ~v; wide_i = ~w;
            end
            if (restart && n == 6) start_i = 1'b0;
            @(negedge clk);
        end
        check(n == exp_busy(w), "R9 busy length", n, exp_busy(w));
        check(done_o == 1'b1, "R9 done at busy fall", done_o, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        check(busy_o == 1'b0, "R2 no second frame", busy_o, 0);
        check(frames == f0 + 1, "R2 one frame per start", frames - f0, 1);
        if (w)
            check(last_cnt == 16, "R5 bit count", last_cnt, 16);
        else
            check(last_cnt == 11, "R4 bit count", last_cnt, 11);
        check(int'(last_word) == exp_word(a, v), w ? "R5/R3 frame bits" : "R4/R3 frame bits",
              int'(last_word), exp_word(a, v));
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(sel_n_o == 1'b1, "R1 select idle", sel_n_o, 1);
        check(sclk_o == 1'b1, "R1 clock idle", sclk_o, 1);
        check(busy_o == 1'b0, "R1 busy idle", busy_o, 0);
        check(done_o == 1'b0, "R1 done idle", done_o, 0);
        // R10 pass-through while idle
        preset_n_i = 1'b0; pwrdn_n_i = 1'b1; #1;
        check(preset_n_o == 1'b0 && pwrdn_n_o == 1'b1, "R10 pass idle",
              {preset_n_o, pwrdn_n_o}, 1);
        preset_n_i = 1'b1; pwrdn_n_i = 1'b0; #1;
        check(preset_n_o == 1'b1 && pwrdn_n_o == 1'b0, "R10 pass idle",
              {preset_n_o, pwrdn_n_o}, 2);
        pwrdn_n_i = 1'b1;

        // directed corners
        run_frame(3'd7, 8'hFF, 1'b0, 1'b0, 1'b0);   // R4 all ones
        run_frame(3'd0, 8'h00, 1'b1, 1'b0, 1'b0);   // R5 all zeros, 16 edges
        run_frame(3'd5, 8'h81, 1'b1, 1'b0, 1'b0);   // R5 pattern
        run_frame(3'd2, 8'h5A, 1'b0, 1'b1, 1'b0);   // R3 inputs change mid-frame
        run_frame(3'd6, 8'hC3, 1'b1, 1'b1, 1'b0);   // R3 in wide mode
        run_frame(3'd1, 8'h3C, 1'b0, 1'b0, 1'b1);   // R2 start while busy

        // R10 pass-through during a transfer
        @(negedge clk);
        start_i = 1'b1; addr_i = 3'd4; value_i = 8'h10; wide_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (7) @(negedge clk);
        preset_n_i = 1'b0; pwrdn_n_i = 1'b0; #1;
        check(busy_o && preset_n_o == 1'b0 && pwrdn_n_o == 1'b0, "R10 pass busy",
              {busy_o, preset_n_o, pwrdn_n_o}, 4);
        preset_n_i = 1'b1; pwrdn_n_i = 1'b1;
        while (busy_o) @(negedge clk);
        check(int'(last_word) == exp_word(3'd4, 8'h10), "R10 frame unaffected",
              int'(last_word), exp_word(3'd4, 8'h10));

        // random frames
        for (int i = 0; i < 24; i++) begin
            run_frame(3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        check(min_level >= HALF, "R8 clock level width", min_level, HALF);
        check(min_gap >= RECOV, "R8 select recovery", min_gap, RECOV);
        if (seed == 0) $display("seed zero");
        finish_run();
    end
endmodule